// File: doc/BRIEF.md
# Two-Wire Slave Byte Reader with Random and Sequential Access

This block is a slave on a two-wire serial bus (I2C style, 7-bit addressing) that gives a bus master read access to a small byte array held inside the block. It watches SCL and SDA from the system clock. It recognises start, repeated start and stop events, and it acknowledges only its own configured device address. It drives SDA through an open-drain enable that can only pull the line low.

A write transfer carries one byte-address. The block acknowledges it and loads that value into an internal pointer. A later read transfer returns bytes starting at the pointer. The read may follow a repeated start, which gives random access, or a fresh start, which gives a current-address read. Each byte that the master acknowledges is followed by the byte at the next address. The pointer wraps at the top of the array. A master not-acknowledge ends the stream.

Each byte fetched for transmission also appears on a registered parallel read port, so neighbouring logic can observe every access.

Top module: `i2cmem_rd_port`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `sda_oe` is 0 and `rd_fire` is 0.
- R2: A start is a falling SDA while SCL is high, and a stop is a rising SDA while SCL is high. After a start, the first eight bits received (MSB first) are the 7-bit device address followed by a direction bit (0 = write, 1 = read). When the address equals `DEV_ADDR`, the block pulls SDA low in the ninth clock.
- R3: When the received address does not equal `DEV_ADDR`, the block leaves SDA released in the ninth clock. It keeps SDA released for all later bytes until the next start.
- R4: In a write transfer, the block acknowledges the byte after the address byte. It then loads the low `AW` bits of that byte into the pointer.
- R5: In a read transfer, after acknowledging the address, the block sends the byte stored at the pointer, MSB first. The array content is fixed: the byte at address a equals ((a*29) mod 256) XOR `SEED`.
- R6: When the master pulls SDA low in the acknowledge clock after a data byte, the block sends the byte at the next address. The address after 2^AW-1 is 0.
- R7: When the master leaves SDA high in the acknowledge clock, the block releases SDA and drives nothing more until the next start. A stop returns the block to idle.
- R8: The pointer advances by one after every transmitted byte, including the last one of a read. A read that begins without a byte address (a current-address read) starts at that pointer.
- R9: A start or repeated start received at any point aborts the byte in progress and returns the block to address reception. The pointer is left unchanged.
- R10: The block changes `sda_oe` only while SCL is low, except when it releases SDA on a start or stop.
- R11: For every byte loaded for transmission, `rd_fire` pulses high for exactly one cycle, with `rd_addr` equal to the byte's address and `rd_data` equal to the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND value) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| rd_fire | output | 1 | One-cycle strobe for each byte fetched for transmission |
| rd_addr | output | AW | Array address of the fetched byte |
| rd_data | output | 8 | Value of the fetched byte |

## Verification
The bench builds the block with `AW` = 4, `DEV_ADDR` = 7'h2C and `SEED` = 8'h5A. The 16-entry array lets a four-byte sequential read starting at address 13 cross the wrap from 15 to 0. The bench tracks the pointer across scenarios, so current-address reads, mismatched addresses and aborted bytes can each be checked against a pointer value the bench computes itself. The device address has a zero LSB, so the bench can flip that bit to produce a mismatching address that differs in a single bit.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_CHK,
    ST_ADDR_ACK,
    ST_WADDR,
    ST_WADDR_CHK,
    ST_WADDR_ACK,
    ST_TX,
    ST_TX_END,
    ST_TX_ACK,
    ST_TX_NEXT,
    ST_IGNORE
  } link_state_e;

  // Fixed array content: a scrambled function of the address.
  function automatic logic [7:0] fill_byte(input int unsigned a, input logic [7:0] seed);
    logic [31:0] p;
    p = a * 32'd29;
    return p[7:0] ^ seed;
  endfunction

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2cmem_rom.sv
module i2cmem_rom #(
  parameter int          AW   = 4,
  parameter logic [7:0]  SEED = 8'h5A
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  import i2cmem_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = fill_byte(i, SEED);
  end

  always_ff @(posedge clk) rdata <= mem[raddr];
endmodule

// File: rtl/i2cmem_fsm.sv
module i2cmem_fsm #(
  parameter int         AW       = 4,
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     sda_lvl,
  input  logic                     start_det,
  input  logic                     stop_det,
  input  logic [7:0]               mem_rdata,
  output logic                     sda_oe,
  output logic [AW-1:0]            ptr,
  output i2cmem_pkg::link_state_e  state,
  output logic                     rd_fire,
  output logic [AW-1:0]            rd_addr,
  output logic [7:0]               rd_data
);
  import i2cmem_pkg::*;

  logic [2:0] cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic       dir_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      dir_rd  <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
      rd_fire <= 1'b0;
      rd_addr <= '0;
      rd_data <= '0;
    end else begin
      rd_fire <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            rx_sh <= {rx_sh[6:0], sda_lvl};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) state <= ST_ADDR_CHK;
          end
          ST_ADDR_CHK: if (scl_fall) begin
            if (rx_sh[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              dir_rd <= rx_sh[0];
              state  <= ST_ADDR_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (dir_rd) begin
              tx_sh   <= mem_rdata;
              sda_oe  <= ~mem_rdata[7];
              cnt     <= '0;
              rd_fire <= 1'b1;
              rd_addr <= ptr;
              rd_data <= mem_rdata;
              state   <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WADDR;
            end
          end
          ST_WADDR: if (scl_rise) begin
            rx_sh <= {rx_sh[6:0], sda_lvl};
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) state <= ST_WADDR_CHK;
          end
          ST_WADDR_CHK: if (scl_fall) begin
            sda_oe <= 1'b1;
            ptr    <= rx_sh[AW-1:0];
            state  <= ST_WADDR_ACK;
          end
          ST_WADDR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_IGNORE;
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) state <= ST_TX_END;
            end else if (scl_fall) begin
              sda_oe <= ~tx_sh[~cnt];
            end
          end
          ST_TX_END: if (scl_fall) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + AW'(1);
            state  <= ST_TX_ACK;
          end
          ST_TX_ACK: if (scl_rise) begin
            state <= sda_lvl ? ST_IGNORE : ST_TX_NEXT;
          end
          ST_TX_NEXT: if (scl_fall) begin
            tx_sh   <= mem_rdata;
            sda_oe  <= ~mem_rdata[7];
            cnt     <= '0;
            rd_fire <= 1'b1;
            rd_addr <= ptr;
            rd_data <= mem_rdata;
            state   <= ST_TX;
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cmem_rd_port.sv
module i2cmem_rd_port #(
  parameter int         AW          = 4,
  parameter logic [6:0] DEV_ADDR    = 7'h2C,
  parameter logic [7:0] SEED        = 8'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  import i2cmem_pkg::*;

  logic scl_s, scl_rise, scl_fall;
  logic sda_s, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic [7:0]    mem_rdata;
  logic [AW-1:0] ptr;
  link_state_e   state;

  i2cmem_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i),
    .level(scl_s), .rise(scl_rise), .fall(scl_fall)
  );

  i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i),
    .level(sda_s), .rise(sda_rise), .fall(sda_fall)
  );

  assign start_det = sda_fall & scl_s;
  assign stop_det  = sda_rise & scl_s;

  i2cmem_rom #(.AW(AW), .SEED(SEED)) u_rom (
    .clk(clk), .raddr(ptr), .rdata(mem_rdata)
  );

  i2cmem_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_s),
    .start_det(start_det), .stop_det(stop_det),
    .mem_rdata(mem_rdata),
    .sda_oe(sda_oe), .ptr(ptr), .state(state),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/i2cmem_rd_chk.sv
module i2cmem_rd_chk #(
  parameter int AW = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    scl_s,
  input logic                    sda_s,
  input logic                    scl_rise,
  input logic                    scl_fall,
  input logic                    start_det,
  input logic                    stop_det,
  input logic                    sda_oe,
  input logic                    rd_fire,
  input logic [AW-1:0]           ptr,
  input i2cmem_pkg::link_state_e state
);
  import i2cmem_pkg::*;

  // R10: drive changes only while SCL is low (bus events excepted)
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    ($changed(sda_oe) && !$past(start_det || stop_det)) |-> !scl_s);

  // R7: master not-acknowledge releases the line and parks the block
  a_r7_nak_release: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_ACK && scl_rise && sda_s && !start_det && !stop_det)
    |=> (!sda_oe && state == ST_IGNORE));

  // R6: pointer steps by one (modulo depth) at the end of each byte
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_END && scl_fall && !start_det && !stop_det)
    |=> ptr == AW'($past(ptr) + 1'b1));

  // R9: any start re-arms address reception and keeps the pointer
  a_r9_start_rearm: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && !sda_oe && $stable(ptr)));

  // R3: an ignored transfer never pulls the line
  a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE && !start_det) |=> !sda_oe);

  // R11: read strobe lasts a single cycle
  a_r11_fire_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> !rd_fire);
endmodule

bind i2cmem_rd_port i2cmem_rd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
  .scl_rise(scl_rise), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .rd_fire(rd_fire), .ptr(ptr), .state(state)
);

// File: tb/test_i2cmem_rd_port.sv
`timescale 1ns/1ps
module test_i2cmem_rd_port;
  localparam int         AW   = 4;
  localparam logic [6:0] DEV  = 7'h2C;
  localparam logic [7:0] SEED = 8'h5A;
  localparam int         Q    = 4;

  logic clk = 1'b0, rst = 1'b1, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, rd_fire;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic sda_line;
  int checks = 0, failures = 0, fires = 0, r10_bad = 0;
  logic [AW-1:0] last_addr;
  logic [7:0]    last_data;
  logic done = 1'b0;
  logic prev_oe;

  assign sda_line = m_sda & ~sda_oe;
  always #2.5 clk = ~clk;

  i2cmem_rd_port #(.AW(AW), .DEV_ADDR(DEV), .SEED(SEED)) i_i2cmem_rd_port (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    prev_oe <= sda_oe;
    if (!rst && m_scl && (sda_oe !== prev_oe)) r10_bad++;
    if (rd_fire) begin fires++; last_addr <= rd_addr; last_data <= rd_data; end
  end

  function automatic logic [7:0] exp_byte(input int a);
    logic [31:0] p;
    p = a * 29;
    return p[7:0] ^ SEED;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic drv, output logic got);
    tick(Q); m_sda = drv; tick(Q); m_scl = 1'b1; tick(Q);
    got = sda_line; tick(Q); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic g;
    for (int i = 7; i >= 0; i--) bit_io(b[i], g);
    bit_io(1'b1, g);
    acked = !g;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic g;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, g); b[i] = g; end
    bit_io(!give_ack, g);
  endtask

  task automatic t_reset();
    tick(3);
    check(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    check(rd_fire == 1'b0, "R1 rd_fire in reset", rd_fire, 0);
    rst = 1'b0;
    tick(1);
    check(sda_oe == 1'b0 && rd_fire == 1'b0, "R1 after release", {sda_oe, rd_fire}, 0);
  endtask

  // dummy write, repeated start, read n bytes
  task automatic t_random(input int addr, input int n);
    logic a; logic [7:0] d; int f0;
    bus_start();
    send_byte({DEV, 1'b0}, a); check(a, "R2 address ack (write)", a, 1);
    send_byte(8'(addr), a);    check(a, "R4 byte address ack", a, 1);
    bus_start();
    send_byte({DEV, 1'b1}, a); check(a, "R5 address ack (read)", a, 1);
    for (int k = 0; k < n; k++) begin
      f0 = fires;
      recv_byte(k != n-1, d);
      check(d == exp_byte((addr + k) % 16), (n > 1) ? "R6 sequential byte" : "R5 random byte",
            d, exp_byte((addr + k) % 16));
      check(fires == f0 + 1 && last_addr == AW'((addr + k) % 16) && last_data == d,
            "R11 read port", {last_addr, last_data}, {AW'((addr + k) % 16), d});
    end
    tick(2);
    check(sda_oe == 1'b0, "R7 released after nak", sda_oe, 0);
    bus_stop();
    check(sda_oe == 1'b0, "R7 idle after stop", sda_oe, 0);
  endtask

  task automatic t_current(input int exp_addr, input string tag);
    logic a; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a); check(a, "R8 current read ack", a, 1);
    recv_byte(1'b0, d);
    check(d == exp_byte(exp_addr), tag, d, exp_byte(exp_addr));
    bus_stop();
  endtask

  task automatic t_wrong();
    logic a;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a); check(!a, "R3 foreign address nak", a, 0);
    send_byte(8'h09, a);               check(!a, "R3 later byte ignored", a, 0);
    bus_stop();
    t_current(2, "R3 pointer untouched by foreign write");
  endtask

  task automatic t_abort();
    logic a, g;
    bus_start();
    send_byte({DEV, 1'b0}, a); check(a, "R9 ack before abort", a, 1);
    bit_io(1'b1, g); bit_io(1'b0, g); bit_io(1'b1, g); bit_io(1'b1, g);
    bus_start();
    send_byte({DEV, 1'b1}, a); check(a, "R9 address after abort", a, 1);
    begin
      logic [7:0] d;
      recv_byte(1'b0, d);
      check(d == exp_byte(3), "R9 pointer kept across abort", d, exp_byte(3));
    end
    bus_stop();
  endtask

  initial begin
    t_reset();
    tick(10);
    t_random(5, 1);                        // pointer -> 6
    t_random(13, 4);                       // 13,14,15,0 ; pointer -> 1
    t_current(1, "R8 current-address read"); // pointer -> 2
    t_wrong();                             // reads 2 ; pointer -> 3
    t_abort();                             // reads 3 ; pointer -> 4
    check(r10_bad == 0, "R10 drive changes while SCL high", r10_bad, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule